// File: doc/BRIEF.md
# Indexed vector gather load engine

This block fetches eight 32-bit elements from scattered memory locations and returns them as one 256-bit vector. A caller hands it a base address, a vector of eight unsigned 32-bit indices and a 2-bit scale code. The block then forms one address per element as base plus the index shifted left by the scale. It sends these addresses out over two load ports that work independently. Port 0 fetches lanes 0 to 3 and port 1 fetches lanes 4 to 7.

The index vector is captured once. Each port keeps its own half and shifts it right by one element for every load that is accepted, so the next index is always in the bottom slot. Every load request carries the number of its destination lane as a 3-bit tag. The memory returns that tag with the data. This lets responses arrive in any order and on either port, and each one is written into its own lane of a collection register.

The assembled vector is shown for exactly one cycle, and only when all eight lanes are present. No partial vector is ever visible. Only one gather is in flight at a time.

Top module: `gather_engine`

## Requirements
- R1: Out of reset, `req_ready` is 1, and `res_valid` and both `ld_req_valid` bits are 0. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle, `req_ready` stays 0 until the result cycle has passed.
- R2: The address of lane l is `req_base + (index_l << req_scale)`, computed modulo 2^32. The scale codes 0, 1, 2 and 3 mean multiply by 1, 2, 4 and 8. Index l is taken from `req_index[32*l+31:32*l]`.
- R3: Port p (p = 0 or 1) requests lanes 4p to 4p+3 in ascending lane order. Each request's `ld_req_tag` equals its lane number.
- R4: Both ports raise `ld_req_valid` in the cycle after a request is accepted. If `ld_req_ready` is held at 1, each port issues its four loads on four consecutive cycles.
- R5: While a port's `ld_req_valid` is 1 and its `ld_req_ready` is 0, its address and tag stay unchanged.
- R6: A response with tag t is written into `res_data[32*t+31:32*t]`, whatever its arrival order. The two ports may both return in the same cycle.
- R7: `res_valid` is 1 for exactly one cycle. That cycle is the one right after the edge that accepted the last of the eight responses, and `res_data` then holds all eight elements.
- R8: Accepting a new gather clears the record of filled lanes. Lanes filled by an earlier gather therefore never count toward the new one.
- R9: `req_ready` returns to 1 in the cycle after the one with `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Gather request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_base | input | 32 | Base byte address |
| req_index | input | 256 | Eight unsigned 32-bit indices, lane 0 in the low bits |
| req_scale | input | 2 | Index scale: 0=x1, 1=x2, 2=x4, 3=x8 |
| ld_req_valid | output | 2 | Load request valid, one bit per port |
| ld_req_ready | input | 2 | Load port accepts request, one bit per port |
| ld_req_addr | output | 64 | Load addresses, 32 bits per port |
| ld_req_tag | output | 6 | Lane tags, 3 bits per port |
| ld_rsp_valid | input | 2 | Load response valid, one bit per port |
| ld_rsp_data | input | 64 | Response data, 32 bits per port |
| ld_rsp_tag | input | 6 | Returned lane tags, 3 bits per port |
| res_valid | output | 1 | Completed vector present, one-cycle pulse |
| res_data | output | 256 | Assembled vector, lane l in bits 32l+31:32l |

## Verification
Two things can happen in the same cycle here. Both ports can deliver responses into different lanes at once, or one port can accept a new load while a response lands in the collection register. A directed run holds both ports ready and uses the same fixed latency on each, so the two ports return in lock step. Random runs vary the ready signal and the latency for each element, so returns come back in scrambled order. The bench checks that a port stayed busy, that lock-step returns happened, and that each assembled vector matches the memory model. It also checks that the result pulse appears exactly one cycle after the last response.

// File: rtl/gather_pkg.sv
// Package: shared types for the gather engine.
// Assumes: the scale code is used directly as a left-shift amount.
package gather_pkg;
    typedef enum logic [1:0] {
        SCALE_X1 = 2'd0,
        SCALE_X2 = 2'd1,
        SCALE_X4 = 2'd2,
        SCALE_X8 = 2'd3
    } scale_e;
endpackage

// File: rtl/gather_port_issue.sv
// Module: one load-issue lane group. It holds one half of the index
// vector, forms base + (index << scale) for the bottom element, and
// shifts the held indices right by one element each time a load is
// accepted.
// Assumes: start is only pulsed while the group is idle.
module gather_port_issue
    import gather_pkg::*;
#(
    parameter int ELEM_W  = 32,
    parameter int LPP     = 4,
    parameter int TAG_W   = 3,
    parameter int PORT_ID = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ELEM_W-1:0]     base,
    input  scale_e                scale,
    input  logic [LPP*ELEM_W-1:0] idx_in,
    input  logic                  ld_ready,
    output logic                  ld_valid,
    output logic [ELEM_W-1:0]     ld_addr,
    output logic [TAG_W-1:0]      ld_tag
);
    localparam int               CNT_W    = (LPP > 1) ? $clog2(LPP) : 1;
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(LPP - 1);
    localparam logic [TAG_W-1:0] TAG_BASE = TAG_W'(PORT_ID * LPP);

    logic                  active;
    logic [CNT_W-1:0]      cnt;
    logic [LPP*ELEM_W-1:0] idx_q;
    logic [ELEM_W-1:0]     base_q;
    scale_e                scale_q;

    // Capture a new gather, then step one element per accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            idx_q   <= '0;
            base_q  <= '0;
            scale_q <= SCALE_X1;
        end else if (start) begin
            active  <= 1'b1;
            cnt     <= '0;
            idx_q   <= idx_in;
            base_q  <= base;
            scale_q <= scale;
        end else if (active && ld_ready) begin
            idx_q <= idx_q >> ELEM_W;
            cnt   <= cnt + CNT_W'(1);
            if (cnt == LAST) begin
                active <= 1'b0;
            end
        end
    end

    // Address of the element now at the bottom slot, with wrap-around.
    always_comb begin
        ld_valid = active;
        ld_addr  = base_q + (idx_q[ELEM_W-1:0] << scale_q);
        ld_tag   = TAG_BASE + TAG_W'(cnt);
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_ready) |=> (ld_valid && $stable(ld_addr) && $stable(ld_tag))); // R5
    AST_ISSUE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ld_valid); // R4
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active); // R1
endmodule

// File: rtl/gather_collect.sv
// Module: collection register. Each response is written into the lane
// named by its tag, and arrived lanes are tracked in a fill mask. The
// module pulses res_valid once every lane is filled.
// Assumes: each lane gets exactly one response per gather.
module gather_collect #(
    parameter int LANES  = 8,
    parameter int ELEM_W = 32,
    parameter int PORTS  = 2,
    parameter int TAG_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [PORTS-1:0]        rsp_valid,
    input  logic [PORTS*ELEM_W-1:0] rsp_data,
    input  logic [PORTS*TAG_W-1:0]  rsp_tag,
    output logic                    busy,
    output logic                    res_valid,
    output logic [LANES*ELEM_W-1:0] res_data
);
    logic [LANES-1:0] fill_q;
    logic [LANES-1:0] lane_hit;
    logic             busy_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ELEM_W-1:0] wdata;
        logic [ELEM_W-1:0] lane_q;

        // Pick the port whose response tag names this lane.
        always_comb begin
            lane_hit[l] = 1'b0;
            wdata       = '0;
            for (int p = 0; p < PORTS; p++) begin
                if (rsp_valid[p] && (rsp_tag[p*TAG_W +: TAG_W] == TAG_W'(l))) begin
                    lane_hit[l] = 1'b1;
                    wdata       = rsp_data[p*ELEM_W +: ELEM_W];
                end
            end
        end

        // Store the element arriving for this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (lane_hit[l]) begin
                lane_q <= wdata;
            end
        end

        assign res_data[l*ELEM_W +: ELEM_W] = lane_q;
    end

    // Fill mask: cleared when a gather starts, set as lanes arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (start) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_q | lane_hit;
        end
    end

    // In-flight flag: set on start, dropped after the result cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
        end else if (res_valid) begin
            busy_q <= 1'b0;
        end
    end

    assign busy      = busy_q;
    assign res_valid = busy_q && (&fill_q);

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R7
    AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (fill_q == '0)); // R8

    for (genvar p = 0; p < PORTS; p++) begin : g_chk
        AST_LANE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[p] |-> !fill_q[rsp_tag[p*TAG_W +: TAG_W]]); // R6
    end
endmodule

// File: rtl/gather_engine.sv
// Module: top of the indexed gather engine. It accepts one request at a
// time, hands each index half to its own issue group, and collects the
// returned elements into a single vector.
// Assumes: LANES divides evenly by PORTS, and the memory returns each
// tag once.
module gather_engine #(
    parameter int LANES  = 8,
    parameter int ELEM_W = 32,
    parameter int PORTS  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic [ELEM_W-1:0]               req_base,
    input  logic [LANES*ELEM_W-1:0]         req_index,
    input  logic [1:0]                      req_scale,
    output logic [PORTS-1:0]                ld_req_valid,
    input  logic [PORTS-1:0]                ld_req_ready,
    output logic [PORTS*ELEM_W-1:0]         ld_req_addr,
    output logic [PORTS*$clog2(LANES)-1:0]  ld_req_tag,
    input  logic [PORTS-1:0]                ld_rsp_valid,
    input  logic [PORTS*ELEM_W-1:0]         ld_rsp_data,
    input  logic [PORTS*$clog2(LANES)-1:0]  ld_rsp_tag,
    output logic                            res_valid,
    output logic [LANES*ELEM_W-1:0]         res_data
);
    import gather_pkg::*;

    localparam int TAG_W = $clog2(LANES);
    localparam int LPP   = LANES / PORTS;

    logic   busy;
    logic   accept;
    scale_e scale_cmd;

    // Only one gather at a time: take a request only while idle.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
        scale_cmd = scale_e'(req_scale);
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        gather_port_issue #(
            .ELEM_W (ELEM_W),
            .LPP    (LPP),
            .TAG_W  (TAG_W),
            .PORT_ID(p)
        ) i_issue (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (accept),
            .base    (req_base),
            .scale   (scale_cmd),
            .idx_in  (req_index[p*LPP*ELEM_W +: LPP*ELEM_W]),
            .ld_ready(ld_req_ready[p]),
            .ld_valid(ld_req_valid[p]),
            .ld_addr (ld_req_addr[p*ELEM_W +: ELEM_W]),
            .ld_tag  (ld_req_tag[p*TAG_W +: TAG_W])
        );
    end

    gather_collect #(
        .LANES (LANES),
        .ELEM_W(ELEM_W),
        .PORTS (PORTS),
        .TAG_W (TAG_W)
    ) i_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .rsp_valid(ld_rsp_valid),
        .rsp_data (ld_rsp_data),
        .rsp_tag  (ld_rsp_tag),
        .busy     (busy),
        .res_valid(res_valid),
        .res_data (res_data)
    );

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R1
    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> req_ready); // R9
endmodule

// File: tb/test_gather_engine.sv
`timescale 1ns/1ps
module test_gather_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_base = '0;
    logic [255:0] req_index = '0;
    logic [1:0]   req_scale = '0;
    logic [1:0]   ld_req_valid;
    logic [1:0]   ld_req_ready = '0;
    logic [63:0]  ld_req_addr;
    logic [5:0]   ld_req_tag;
    logic [1:0]   ld_rsp_valid = '0;
    logic [63:0]  ld_rsp_data = '0;
    logic [5:0]   ld_rsp_tag = '0;
    logic         res_valid;
    logic [255:0] res_data;

    always #2 clk = ~clk;

    gather_engine i_gather_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_index(req_index), .req_scale(req_scale),
        .ld_req_valid(ld_req_valid), .ld_req_ready(ld_req_ready),
        .ld_req_addr(ld_req_addr), .ld_req_tag(ld_req_tag),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data), .ld_rsp_tag(ld_rsp_tag),
        .res_valid(res_valid), .res_data(res_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit fast_mode = 1'b0;
    int fixed_lat = 1;

    logic [31:0] exp_base;
    logic [1:0]  exp_scale;
    logic [31:0] exp_idx [8];
    int          next_lane [2];
    int          hs_cyc [8];
    int          rsp_count = 0;
    int          last_rsp_cyc = 0;
    int          dual_rsp = 0;

    int          pend_n [2];
    int          pend_dly [2][8];
    logic [31:0] pend_addr [2][8];
    logic [2:0]  pend_tag [2][8];
    bit          prev_stall [2];
    logic [31:0] prev_addr [2];
    logic [2:0]  prev_tag [2];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [31:0] lane_addr(input int l);
        return exp_base + exp_idx[l] * (32'd1 << exp_scale);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model: records load handshakes and returns data after a delay.
    always @(negedge clk) begin
        cyc++;
        for (int p = 0; p < 2; p++) begin
            logic [31:0] a;
            logic [2:0]  t;
            bit          rdy;
            int          nel;
            int          k;
            int          sel;
            a = ld_req_addr[p*32 +: 32];
            t = ld_req_tag[p*3 +: 3];
            if (prev_stall[p] && ld_req_valid[p])
                chk((a == prev_addr[p]) && (t == prev_tag[p]), "R5", "stalled request changed",
                    {a, 5'd0, t}, {prev_addr[p], 5'd0, prev_tag[p]});
            for (int i = 0; i < pend_n[p]; i++) pend_dly[p][i]--;
            nel = 0;
            for (int i = 0; i < pend_n[p]; i++) if (pend_dly[p][i] <= 0) nel++;
            ld_rsp_valid[p] = 1'b0;
            if (nel > 0) begin
                k = $urandom_range(nel - 1);
                sel = -1;
                for (int i = 0; i < pend_n[p]; i++) begin
                    if (pend_dly[p][i] <= 0) begin
                        if (k == 0 && sel < 0) sel = i;
                        k--;
                    end
                end
                ld_rsp_valid[p] = 1'b1;
                ld_rsp_tag[p*3 +: 3] = pend_tag[p][sel];
                ld_rsp_data[p*32 +: 32] = mem_word(pend_addr[p][sel]);
                pend_tag[p][sel] = pend_tag[p][pend_n[p]-1];
                pend_addr[p][sel] = pend_addr[p][pend_n[p]-1];
                pend_dly[p][sel] = pend_dly[p][pend_n[p]-1];
                pend_n[p]--;
                rsp_count++;
                last_rsp_cyc = cyc;
            end
            rdy = fast_mode ? 1'b1 : ($urandom_range(3) != 0);
            ld_req_ready[p] = rdy;
            prev_stall[p] = ld_req_valid[p] && !rdy;
            prev_addr[p] = a;
            prev_tag[p] = t;
            if (ld_req_valid[p] && rdy) begin
                chk((next_lane[p] < 4) && (t == 3'(p*4 + next_lane[p])), "R3", "lane tag order",
                    t, 3'(p*4 + next_lane[p]));
                chk(a == lane_addr(t), "R2", "element address", a, lane_addr(t));
                hs_cyc[t] = cyc;
                pend_tag[p][pend_n[p]] = t;
                pend_addr[p][pend_n[p]] = a;
                pend_dly[p][pend_n[p]] = fast_mode ? fixed_lat : (1 + $urandom_range(5));
                pend_n[p]++;
                next_lane[p]++;
            end
        end
        if (&ld_rsp_valid) dual_rsp++;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic do_gather(input logic [31:0] base, input logic [1:0] scale,
                             input logic [255:0] idx);
        int acc_cyc;
        int waited;
        logic [255:0] exp_vec;
        exp_base = base;
        exp_scale = scale;
        for (int l = 0; l < 8; l++) exp_idx[l] = idx[l*32 +: 32];
        next_lane[0] = 0;
        next_lane[1] = 0;
        rsp_count = 0;
        step();
        chk(req_ready == 1'b1, "R9", "ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_base = base;
        req_scale = scale;
        req_index = idx;
        acc_cyc = cyc;
        step();
        req_valid = 1'b0;
        req_index = ~idx;
        req_base = ~base;
        chk(req_ready == 1'b0, "R1", "ready low while in flight", req_ready, 0);
        waited = 0;
        while (!res_valid && waited < 300) begin
            step();
            waited++;
        end
        if (!res_valid) begin
            chk(1'b0, "R7", "watchdog: no result", 0, 1);
            return;
        end
        for (int l = 0; l < 8; l++) exp_vec[l*32 +: 32] = mem_word(lane_addr(l));
        chk(rsp_count == 8, "R7 R8", "result shown before all lanes", rsp_count, 8);
        chk(cyc == last_rsp_cyc + 1, "R7", "result one cycle after last response",
            cyc, last_rsp_cyc + 1);
        chk(res_data == exp_vec, "R6", "assembled vector", res_data, exp_vec);
        if (fast_mode)
            for (int l = 0; l < 8; l++)
                chk(hs_cyc[l] == acc_cyc + 1 + (l % 4), "R4", "issue cycle",
                    hs_cyc[l], acc_cyc + 1 + (l % 4));
        step();
        chk(res_valid == 1'b0, "R7", "result pulse length", res_valid, 0);
        chk(req_ready == 1'b1, "R9", "ready after result", req_ready, 1);
    endtask

    initial begin
        logic [255:0] v;
        void'($urandom(32'd4242));
        pend_n[0] = 0; pend_n[1] = 0;
        prev_stall[0] = 0; prev_stall[1] = 0;
        next_lane[0] = 0; next_lane[1] = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(res_valid == 1'b0, "R1", "reset result", res_valid, 0);
        chk(ld_req_valid == 2'b00, "R1", "reset load valid", ld_req_valid, 0);

        // Directed: lock-step ports, both returning in the same cycles.
        fast_mode = 1'b1;
        fixed_lat = 2;
        for (int l = 0; l < 8; l++) v[l*32 +: 32] = 32'(l);
        dual_rsp = 0;
        do_gather(32'h0000_1000, 2'd2, v);
        chk(dual_rsp > 0, "R6", "dual-port return in one cycle", dual_rsp, 1);
        fixed_lat = 1;
        do_gather(32'h0000_0400, 2'd0, '0);
        fixed_lat = 4;
        for (int l = 0; l < 8; l++) v[l*32 +: 32] = 32'hFFFF_FFFF - 32'(l);
        do_gather(32'hFFFF_FFF0, 2'd3, v);

        // Random ready and latency, scrambled return order.
        fast_mode = 1'b0;
        do_gather(32'h8000_0000, 2'd1, v);
        for (int n = 0; n < 40; n++) begin
            for (int l = 0; l < 8; l++) v[l*32 +: 32] = $urandom;
            do_gather($urandom, 2'($urandom_range(3)), v);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R7: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule